// File: doc/BRIEF.md
# I2C Target Front End

This block sits between a two-wire I2C bus and a set of byte-level targets. It samples the SCL and SDA wire levels with the system clock and finds START and STOP conditions. It shifts in address and data bytes and answers each byte on the ninth clock with ACK or NACK. During reads it shifts out data bytes. Its only bus output is an SDA drive level, where 1 releases the line and 0 pulls it low. The bus is open drain, so the wire is the AND of all drivers.

Toward the inside, the block calls the targets through single-cycle strobes. A present-check takes a combinational answer. A start strobe carries the target address and the direction. A write strobe carries a byte and takes back a combinational ack. A read strobe takes a byte in the same cycle. A stop strobe goes to the target that was started. Each ack decides, byte by byte, how the ninth clock is answered. The block supports 7-bit addressing, write transfers, read transfers, reads ended by a master NACK, and repeated START. It does not stretch the clock or filter glitches.

Top module: `i2c_target_front`

## Requirements
- R1: A fall of SDA while SCL is high is a START. It is accepted from idle even if SCL never went low first. A rise of SDA while SCL is high is a STOP. SDA changes while SCL is low have no effect.
- R2: Bits are sampled on SCL rising edges, most significant bit first. The first byte after a START holds the target address in bits 7:1 and the direction in bit 0, where 1 means read.
- R3: If no target answers the present-check for that address, the ninth clock is left released (NACK). No start strobe is issued, and the rest of the transfer is ignored until the next START.
- R4: A start strobe, carrying the address and the direction, is issued only when no transfer is active or when the address differs from the active one. A repeated START to the active target issues no second start strobe.
- R5: In a write transfer, each data byte produces one write strobe carrying that byte. An ack of 1 pulls SDA low for the ninth clock. An ack of 0 leaves SDA released, and later bytes then produce no write strobe until the next START.
- R6: In a read transfer, the first byte is fetched by a read strobe on the SCL fall that ends the address ACK. Each byte is then driven on SDA, most significant bit first.
- R7: In a read, a low SDA on the master's acknowledge clock fetches the next byte. A high SDA ends the transfer: no further read strobe is issued and SDA stays released.
- R8: A STOP produces a stop strobe for the active address only if a start strobe was issued and the transfer was not invalidated since. Otherwise no strobe is produced.
- R9: Every strobe lasts one clock cycle, and at most one strobe is active in any cycle.
- R10: During reset and after it, SDA is released and no strobe is active.
- R11: The SDA drive level never changes while the synchronized SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL wire level, asynchronous |
| sdaIn | input | 1 | SDA wire level, asynchronous |
| sdaDrive | output | 1 | SDA drive: 0 pulls the line low, 1 releases it |
| tgtAddr | output | 7 | Address being probed, or the address of the active target |
| tgtRead | output | 1 | Direction belonging to tgtAddr (1 = read) |
| tgtPresent | input | 1 | Combinational present answer for tgtAddr |
| startStb | output | 1 | Start strobe to the target |
| writeStb | output | 1 | Write-byte strobe |
| writeData | output | 8 | Byte carried by writeStb |
| writeAck | input | 1 | Combinational ack for writeStb (1 = ACK) |
| readStb | output | 1 | Read-byte strobe |
| readData | input | 8 | Byte returned during readStb |
| stopStb | output | 1 | Stop strobe to the active target |

## Verification
The bench builds the block with SYNC_STAGES set to 3, one stage more than the default. This makes the response to every wire edge one cycle later, so every ACK setup and every data-bit change after an SCL fall is checked with the longer latency. The bench drives each bus phase for 8 clocks, which keeps that latency inside the SCL low time. It also runs two present target addresses and one absent address. This reaches the cases of a NACKed probe, a repeated START to the same target, and a repeated START to a different target.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RECV,
    ST_PROC,
    ST_ACKQ,
    ST_ACK,
    ST_ACKHOLD,
    ST_NAK,
    ST_TX,
    ST_MACK,
    ST_RDNEXT
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCount;
    logic shiftIn;
    logic countTx;
    logic shiftTx;
    logic loadRead;
    logic armFirst;
    logic takeAddr;
    logic dropAddr;
  } dpCmd_t;

endpackage

// File: rtl/i2c_tgt_line.sv
module i2c_tgt_line #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncOut;
  logic [LINES-1:0] prevOut;

  assign rawIn = {sdaIn, sclIn};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      logic              prevBit;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe    <= '1;
          prevBit <= 1'b1;
        end else begin
          pipe    <= {pipe[STAGES-2:0], rawIn[g]};
          prevBit <= pipe[STAGES-1];
        end
      end

      assign syncOut[g] = pipe[STAGES-1];
      assign prevOut[g] = prevBit;
    end
  endgenerate

  logic sclPrev, sdaPrev;

  assign sclSync = syncOut[0];
  assign sdaSync = syncOut[1];
  assign sclPrev = prevOut[0];
  assign sdaPrev = prevOut[1];

  assign sclRise = sclSync & ~sclPrev;
  assign sclFall = ~sclSync & sclPrev;
  // start needs only SCL high now; stop needs SCL high on both samples
  assign startEv = sclSync & sdaPrev & ~sdaSync;
  assign stopEv  = sclSync & sclPrev & ~sdaPrev & sdaSync;

endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpCmd_t            cmd,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] readData,
  output logic [BYTE_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [ADDR_W-1:0] activeAddr,
  output logic              activeValid,
  output logic              readMode,
  output logic              firstByte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (cmd.clrCount) bitCnt <= '0;
      if (cmd.shiftIn) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
        bitCnt   <= bitCnt + CNT_W'(1);
      end
      if (cmd.countTx) bitCnt <= bitCnt + CNT_W'(1);
      if (cmd.shiftTx) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
      if (cmd.loadRead) begin
        shiftReg <= readData;
        bitCnt   <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeAddr  <= '0;
      activeValid <= 1'b0;
      readMode    <= 1'b0;
      firstByte   <= 1'b0;
    end else begin
      if (cmd.armFirst) firstByte <= 1'b1;
      if (cmd.takeAddr) begin
        activeAddr  <= shiftReg[BYTE_W-1:1];
        readMode    <= shiftReg[0];
        activeValid <= 1'b1;
        firstByte   <= 1'b0;
      end
      if (cmd.dropAddr) begin
        activeValid <= 1'b0;
        firstByte   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] shiftReg,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [ADDR_W-1:0] activeAddr,
  input  logic              activeValid,
  input  logic              readMode,
  input  logic              firstByte,
  input  logic              tgtPresent,
  input  logic              writeAck,
  output dpCmd_t            cmd,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic              tgtRead,
  output logic              startStb,
  output logic              writeStb,
  output logic              readStb,
  output logic              stopStb,
  output logic              sdaDrive
);

  tgtState_t state, nextState;

  logic [ADDR_W-1:0] addrByte;
  logic              probing;

  assign addrByte = shiftReg[BYTE_W-1:1];
  assign probing  = (state == ST_PROC) && firstByte;
  assign tgtAddr  = probing ? addrByte : activeAddr;
  assign tgtRead  = probing ? shiftReg[0] : readMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    startStb  = 1'b0;
    writeStb  = 1'b0;
    readStb   = 1'b0;
    stopStb   = 1'b0;
    if (stopEv) begin
      stopStb      = activeValid;
      cmd.dropAddr = 1'b1;
      nextState    = ST_IDLE;
    end else if (startEv) begin
      cmd.clrCount = 1'b1;
      cmd.armFirst = 1'b1;
      nextState    = ST_RECV;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            if (bitCnt == CNT_W'(BYTE_W - 1)) nextState = ST_PROC;
          end
        end
        ST_PROC: begin
          if (firstByte) begin
            if (!tgtPresent) begin
              cmd.dropAddr = 1'b1;
              nextState    = ST_NAK;
            end else begin
              startStb     = !activeValid || (activeAddr != addrByte);
              cmd.takeAddr = 1'b1;
              nextState    = ST_ACKQ;
            end
          end else if (!readMode) begin
            writeStb  = 1'b1;
            nextState = writeAck ? ST_ACKQ : ST_NAK;
          end else begin
            nextState = ST_NAK;
          end
        end
        ST_ACKQ: begin
          if (sclFall) nextState = ST_ACK;
        end
        ST_ACK: begin
          if (sclRise) nextState = ST_ACKHOLD;
        end
        ST_ACKHOLD: begin
          if (sclFall) begin
            if (readMode) begin
              readStb      = 1'b1;
              cmd.loadRead = 1'b1;
              nextState    = ST_TX;
            end else begin
              cmd.clrCount = 1'b1;
              nextState    = ST_RECV;
            end
          end
        end
        ST_NAK: begin
          if (sclRise) nextState = ST_IDLE;
        end
        ST_TX: begin
          if (sclRise) cmd.countTx = 1'b1;
          if (sclFall) begin
            if (bitCnt == CNT_W'(BYTE_W)) nextState = ST_MACK;
            else cmd.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) nextState = sdaBit ? ST_IDLE : ST_RDNEXT;
        end
        ST_RDNEXT: begin
          if (sclFall) begin
            readStb      = 1'b1;
            cmd.loadRead = 1'b1;
            nextState    = ST_TX;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ACK, ST_ACKHOLD: sdaDrive = 1'b0;
      ST_TX:              sdaDrive = shiftReg[BYTE_W-1];
      default:            sdaDrive = 1'b1;
    endcase
  end

endmodule

// File: rtl/i2c_target_front.sv
module i2c_target_front
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrive,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic              tgtRead,
  input  logic              tgtPresent,
  output logic              startStb,
  output logic              writeStb,
  output logic [BYTE_W-1:0] writeData,
  input  logic              writeAck,
  output logic              readStb,
  input  logic [BYTE_W-1:0] readData,
  output logic              stopStb
);

  logic sclSync, sdaSync, sclRise, sclFall, startEv, stopEv;

  dpCmd_t            cmd;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] activeAddr;
  logic              activeValid, readMode, firstByte;

  i2c_tgt_line #(.STAGES(SYNC_STAGES)) i_line (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv)
  );

  i2c_tgt_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaBit(sdaSync),
    .shiftReg(shiftReg), .bitCnt(bitCnt), .activeAddr(activeAddr),
    .activeValid(activeValid), .readMode(readMode), .firstByte(firstByte),
    .tgtPresent(tgtPresent), .writeAck(writeAck), .cmd(cmd),
    .tgtAddr(tgtAddr), .tgtRead(tgtRead), .startStb(startStb),
    .writeStb(writeStb), .readStb(readStb), .stopStb(stopStb),
    .sdaDrive(sdaDrive)
  );

  i2c_tgt_dp i_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sdaBit(sdaSync),
    .readData(readData), .shiftReg(shiftReg), .bitCnt(bitCnt),
    .activeAddr(activeAddr), .activeValid(activeValid),
    .readMode(readMode), .firstByte(firstByte)
  );

  assign writeData = shiftReg;

endmodule

// File: rtl/i2c_target_front_chk.sv
module i2c_target_front_chk (
  input logic clk,
  input logic rst_n,
  input logic sclSync,
  input logic sdaDrive,
  input logic tgtPresent,
  input logic tgtRead,
  input logic startStb,
  input logic writeStb,
  input logic readStb,
  input logic stopStb
);

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({startStb, writeStb, readStb, stopStb}));

  assert_start_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    startStb |-> tgtPresent);

  assert_write_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    writeStb |-> !tgtRead);

  assert_read_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    readStb |-> tgtRead);

  assert_sda_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sclSync && $past(sclSync)) |-> $stable(sdaDrive));

  assert_reset_release_R10: assert property (@(posedge clk)
    !rst_n |-> (sdaDrive && !startStb && !writeStb && !readStb && !stopStb));

endmodule

bind i2c_target_front i2c_target_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclSync(sclSync), .sdaDrive(sdaDrive),
  .tgtPresent(tgtPresent), .tgtRead(tgtRead), .startStb(startStb),
  .writeStb(writeStb), .readStb(readStb), .stopStb(stopStb)
);

// File: tb/test_i2c_target_front.sv
`timescale 1ns/1ps
module test_i2c_target_front;

  localparam int QTR     = 8;
  localparam int K_START = 1;
  localparam int K_WRITE = 2;
  localparam int K_READ  = 3;
  localparam int K_STOP  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic mScl, mSda, ackEnable;
  logic sdaDrive, sdaLine;
  logic [6:0] tgtAddr;
  logic tgtRead, tgtPresent, startStb, writeStb, readStb, stopStb, writeAck;
  logic [7:0] writeData, readData;
  logic [7:0] rdIdx = 8'd0;
  int checks = 0;
  int failures = 0;
  int expRd = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [6:0] addr;
    logic       rd;
    logic [7:0] data;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  assign sdaLine    = mSda & sdaDrive;
  assign tgtPresent = (tgtAddr == 7'h50) || (tgtAddr == 7'h51);
  assign writeAck   = ackEnable;

  function automatic logic [7:0] rdPattern(input int i);
    return 8'hC3 + 8'(i) * 8'h1D;
  endfunction

  assign readData = rdPattern(int'(rdIdx));
  always @(posedge clk) if (readStb) rdIdx <= rdIdx + 8'd1;

  i2c_target_front #(.SYNC_STAGES(3)) i_i2c_target_front (
    .clk(clk), .rst_n(rst_n), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaDrive(sdaDrive), .tgtAddr(tgtAddr), .tgtRead(tgtRead),
    .tgtPresent(tgtPresent), .startStb(startStb), .writeStb(writeStb),
    .writeData(writeData), .writeAck(writeAck), .readStb(readStb),
    .readData(readData), .stopStb(stopStb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expectItem(input int kind, input logic [6:0] a,
                            input logic rd, input logic [7:0] d);
    expItem_t it;
    it.kind = kind; it.addr = a; it.rd = rd; it.data = d;
    expQ.push_back(it);
  endtask

  task automatic expectRead(input logic [6:0] a);
    expectItem(K_READ, a, 1'b1, rdPattern(expRd));
    expRd++;
  endtask

  task automatic observe(input int kind, input logic [6:0] a,
                         input logic rd, input logic [7:0] d);
    expItem_t it;
    string req;
    req = (kind == K_START) ? "R4" : (kind == K_WRITE) ? "R5" :
          (kind == K_READ) ? "R6" : "R8";
    if (expQ.size() == 0) begin
      check(1'b0, req, "unexpected strobe kind", kind, 0);
    end else begin
      it = expQ.pop_front();
      check(it.kind == kind, req, "strobe kind", kind, it.kind);
      check(it.addr == a, req, "strobe address", int'(a), int'(it.addr));
      if (kind == K_START) check(it.rd == rd, req, "start direction", int'(rd), int'(it.rd));
      if (kind == K_WRITE || kind == K_READ)
        check(it.data == d, req, "strobe data", int'(d), int'(it.data));
    end
  endtask

  // monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (startStb || writeStb || readStb || stopStb)
        check($countones({startStb, writeStb, readStb, stopStb}) == 1, "R9",
              "strobes in one cycle",
              $countones({startStb, writeStb, readStb, stopStb}), 1);
      if (startStb) observe(K_START, tgtAddr, tgtRead, 8'h00);
      if (writeStb) observe(K_WRITE, tgtAddr, tgtRead, writeData);
      if (readStb)  observe(K_READ, tgtAddr, tgtRead, readData);
      if (stopStb)  observe(K_STOP, tgtAddr, tgtRead, 8'h00);
    end
  end

  task automatic quarter();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b0; quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic busStop();
    mSda = 1'b0; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b1; quarter();
  endtask

  task automatic clockOut(input logic b, output logic seen);
    logic late;
    mSda = b; quarter();
    mScl = 1'b1; quarter();
    seen = sdaLine;
    repeat (QTR - 1) @(negedge clk);
    late = sdaLine;
    check(late == seen, "R11", "SDA moved while SCL high", int'(late), int'(seen));
    @(negedge clk);
    mScl = 1'b0; quarter();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockOut(b[i], s);
    clockOut(1'b1, ack);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockOut(1'b1, s);
      b[i] = s;
    end
    clockOut(ackIt ? 1'b0 : 1'b1, s);
  endtask

  task automatic settle();
    quarter(); quarter();
  endtask

  initial begin
    logic ack;
    logic [7:0] got;
    mScl = 1'b1; mSda = 1'b1; ackEnable = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(sdaDrive == 1'b1, "R10", "SDA during reset", int'(sdaDrive), 1);
    check(!(startStb || writeStb || readStb || stopStb), "R10", "strobes during reset",
          int'({startStb, writeStb, readStb, stopStb}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sdaDrive == 1'b1, "R10", "SDA after reset", int'(sdaDrive), 1);

    // plain write of two bytes to 0x50
    expectItem(K_START, 7'h50, 1'b0, 8'h00);
    expectItem(K_WRITE, 7'h50, 1'b0, 8'h3C);
    expectItem(K_WRITE, 7'h50, 1'b0, 8'hC5);
    expectItem(K_STOP, 7'h50, 1'b0, 8'h00);
    busStart();
    sendByte(8'hA0, ack);
    check(ack == 1'b0, "R1", "address ACK after START from idle", int'(ack), 0);
    sendByte(8'h3C, ack);
    check(ack == 1'b0, "R2", "data byte ACK", int'(ack), 0);
    sendByte(8'hC5, ack);
    check(ack == 1'b0, "R5", "data byte ACK", int'(ack), 0);
    busStop(); settle();
    check(expQ.size() == 0, "R8", "pending items after write", expQ.size(), 0);

    // absent address 0x21
    busStart();
    sendByte(8'h42, ack);
    check(ack == 1'b1, "R3", "NACK for absent address", int'(ack), 1);
    sendByte(8'h11, ack);
    check(ack == 1'b1, "R3", "byte after NACK ignored", int'(ack), 1);
    busStop(); settle();
    check(expQ.size() == 0, "R3", "pending items after absent probe", expQ.size(), 0);

    // write refused by target
    expectItem(K_START, 7'h50, 1'b0, 8'h00);
    expectItem(K_WRITE, 7'h50, 1'b0, 8'h77);
    expectItem(K_STOP, 7'h50, 1'b0, 8'h00);
    busStart();
    sendByte(8'hA0, ack);
    check(ack == 1'b0, "R2", "address ACK", int'(ack), 0);
    ackEnable = 1'b0;
    sendByte(8'h77, ack);
    check(ack == 1'b1, "R5", "NACK on refused write", int'(ack), 1);
    sendByte(8'h88, ack);
    check(ack == 1'b1, "R5", "byte after refused write ignored", int'(ack), 1);
    ackEnable = 1'b1;
    // SDA wiggle while SCL low has no effect
    mSda = 1'b0; quarter(); mSda = 1'b1; quarter();
    busStop(); settle();
    check(expQ.size() == 0, "R8", "pending items after refused write", expQ.size(), 0);

    // write, repeated START, read same target
    expectItem(K_START, 7'h50, 1'b0, 8'h00);
    expectItem(K_WRITE, 7'h50, 1'b0, 8'h10);
    expectRead(7'h50); expectRead(7'h50); expectRead(7'h50);
    expectItem(K_STOP, 7'h50, 1'b1, 8'h00);
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h10, ack);
    busStart();
    sendByte(8'hA1, ack);
    check(ack == 1'b0, "R4", "ACK after repeated START", int'(ack), 0);
    recvByte(1'b1, got);
    check(got == rdPattern(expRd - 3), "R6", "read byte 0", int'(got), int'(rdPattern(expRd - 3)));
    recvByte(1'b1, got);
    check(got == rdPattern(expRd - 2), "R7", "read byte after master ACK", int'(got), int'(rdPattern(expRd - 2)));
    recvByte(1'b0, got);
    check(got == rdPattern(expRd - 1), "R6", "read byte 2", int'(got), int'(rdPattern(expRd - 1)));
    quarter();
    check(sdaDrive == 1'b1, "R7", "SDA released after master NACK", int'(sdaDrive), 1);
    busStop(); settle();
    check(expQ.size() == 0, "R7", "pending items after read", expQ.size(), 0);

    // repeated START to a different target
    expectItem(K_START, 7'h50, 1'b0, 8'h00);
    expectItem(K_START, 7'h51, 1'b1, 8'h00);
    expectRead(7'h51);
    expectItem(K_STOP, 7'h51, 1'b1, 8'h00);
    busStart();
    sendByte(8'hA0, ack);
    busStart();
    sendByte(8'hA3, ack);
    check(ack == 1'b0, "R4", "ACK for new target", int'(ack), 0);
    recvByte(1'b0, got);
    check(got == rdPattern(expRd - 1), "R6", "read from second target", int'(got), int'(rdPattern(expRd - 1)));
    busStop(); settle();
    check(expQ.size() == 0, "R4", "pending items after target switch", expQ.size(), 0);

    // START then STOP with nothing addressed
    busStart();
    busStop(); settle();
    check(expQ.size() == 0, "R8", "no stop strobe without transfer", expQ.size(), 0);
    check(sdaDrive == 1'b1, "R1", "SDA released at end", int'(sdaDrive), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog all actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule